// File: doc/BRIEF.md
# Configurable Three-Output Logic Macrocell

This block is one logic cell of a programmable logic fabric. It receives four sum-of-products terms from an upstream product-term array, named A, B, C and D, plus a set of static configuration ports. It holds one storage bit whose next-state rule can be data-follow, toggle or set/clear pairing. The configuration gives each sum term a role: A is the register's data, toggle or set input; B can be the clear-pair input, a local preset or just a signal to route out; C can be the register clock, a local clear or a routed signal; D can be the register clock, the enable for the attached pin driver or a buried feedback node.

Three outputs leave the cell: one toward the pin cell, one fed back into the array and one output enable. The pin and feedback outputs each pick either the stored bit or one of the raw sum terms. So one cell can carry a registered function and a combinational function at the same time. A chip-wide type override lets a cell set up for data-follow behave as a toggle or set/clear register while the override is high. A counter can then load in one mode and count in the other without extra product terms.

All logic runs on one fabric clock `clk`. The register's own clock, whether the global system clock level or a sum term, is sampled each fabric cycle. A rising edge of that level after the per-cell polarity inversion acts as the update strobe.

Top module: `logic_macrocell`

## Requirements
- R1: A high `rst` at a `clk` edge clears the stored bit and drives `pin_o`, `fb_o` and `oe_o` low on that edge. The first strobe after reset needs a genuine low-to-high transition of the selected clock level.
- R2: With an effective type of data-follow (`cfg_kind` 0, or the reserved value 3), a strobe loads the stored bit from A.
- R3: With an effective type of toggle (`cfg_kind` 1), a strobe inverts the stored bit when A is 1 and leaves it unchanged when A is 0.
- R4: With an effective type of set/clear pair (`cfg_kind` 2), J is A and K is B when `cfg_b_role` is 0 (otherwise K is 0). On a strobe, J/K of 1/1 inverts, 0/0 holds, 1/0 sets and 0/1 clears.
- R5: While `type_ovr` is high, a cell whose `cfg_kind` selects data-follow acts as toggle when `cfg_ovr_jk` is 0 and as set/clear pair when it is 1. Cells configured as toggle or set/clear pair are not affected.
- R6: The strobe source is C when `cfg_c_role` is 0, otherwise D when `cfg_d_role` is 0, otherwise `sys_clk`. The source level is XORed with `cfg_clk_inv`, and a strobe occurs in a `clk` cycle where that level is 1 and was 0 at the previous `clk` edge. The bit updates at that same `clk` edge.
- R7: Without a strobe, clear or preset, the stored bit keeps its value.
- R8: Clear is `glob_rst` OR (C AND `cfg_c_role` is 1). It zeroes the stored bit at the next `clk` edge whether or not there is a strobe, and it wins over preset.
- R9: Preset is `glob_pre` OR (B AND `cfg_b_role` is 1). Without clear, it sets the stored bit at the next `clk` edge whether or not there is a strobe.
- R10: `pin_o` shows, one `clk` cycle later, the bit chosen by `cfg_pin_sel`: 0 the stored bit as updated on that edge, 1 A, 2 B, 3 C.
- R11: `fb_o` shows, one `clk` cycle later, the bit chosen by `cfg_fb_sel`: 0 the updated stored bit, 1 A, 2 B, 3 D.
- R12: `oe_o` is D registered one cycle when `cfg_d_role` is 1, and 1 for every other D role.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sum_a | input | 1 | Sum term A |
| sum_b | input | 1 | Sum term B |
| sum_c | input | 1 | Sum term C |
| sum_d | input | 1 | Sum term D |
| sys_clk | input | 1 | Global system clock level |
| glob_pre | input | 1 | Global preset |
| glob_rst | input | 1 | Global clear |
| type_ovr | input | 1 | Global register-type override |
| cfg_kind | input | 2 | Register type: 0 data, 1 toggle, 2 set/clear pair, 3 data |
| cfg_ovr_jk | input | 1 | Override target: 0 toggle, 1 set/clear pair |
| cfg_b_role | input | 2 | B role: 0 K input, 1 preset, 2/3 routed only |
| cfg_c_role | input | 2 | C role: 0 clock, 1 clear, 2/3 routed only |
| cfg_d_role | input | 2 | D role: 0 clock, 1 output enable, 2/3 feedback only |
| cfg_clk_inv | input | 1 | Clock polarity: 1 selects the falling edge of the source |
| cfg_pin_sel | input | 2 | Pin output source: 0 Q, 1 A, 2 B, 3 C |
| cfg_fb_sel | input | 2 | Feedback output source: 0 Q, 1 A, 2 B, 3 D |
| pin_o | output | 1 | Registered output toward the pin cell |
| fb_o | output | 1 | Registered feedback toward the array |
| oe_o | output | 1 | Registered output enable |

## Verification
The assertions assume that the configuration ports change only while `rst` is high. A mid-run change of clock source would mix the held level of one source with the live level of another. The assertions also assume that the sum terms and global controls are settled at each `clk` edge. The stimulus therefore loads a new configuration only across a one-cycle reset and then holds it for a whole segment. It drives every data and control bit at the falling edge of `clk`, so the level, strobe and data all come from the same sample.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int ROLE_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    KIND_D   = 2'd0,
    KIND_T   = 2'd1,
    KIND_JK  = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;

  localparam logic [ROLE_W-1:0] B_ROLE_K   = 2'd0;
  localparam logic [ROLE_W-1:0] B_ROLE_PRE = 2'd1;
  localparam logic [ROLE_W-1:0] C_ROLE_CLK = 2'd0;
  localparam logic [ROLE_W-1:0] C_ROLE_CLR = 2'd1;
  localparam logic [ROLE_W-1:0] D_ROLE_CLK = 2'd0;
  localparam logic [ROLE_W-1:0] D_ROLE_OE  = 2'd1;

  localparam logic [SEL_W-1:0] SEL_Q  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_A  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_B  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CD = 2'd3;
endpackage

// File: rtl/mc_clock_edge.sv
module mc_clock_edge (
  input  logic clk,
  input  logic rst,
  input  logic use_c,
  input  logic use_d,
  input  logic lvl_c,
  input  logic lvl_d,
  input  logic lvl_sys,
  input  logic invert,
  output logic strobe
);
  logic lvl;
  logic lvl_prev;

  always_comb begin
    if (use_c)      lvl = lvl_c ^ invert;
    else if (use_d) lvl = lvl_d ^ invert;
    else            lvl = lvl_sys ^ invert;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b1;
    else     lvl_prev <= lvl;
  end

  assign strobe = lvl & ~lvl_prev;

  // a strobe needs a low sample first, so two in a row cannot occur
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/mc_reg_core.sv
module mc_reg_core
  import mc_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  strobe,
  input  kind_e kind,
  input  logic  ovr,
  input  logic  ovr_jk,
  input  logic  din,
  input  logic  kin,
  input  logic  clr,
  input  logic  set,
  output logic  q,
  output logic  q_nxt
);
  kind_e kind_eff;

  always_comb begin
    kind_eff = kind;
    if (kind == KIND_RSV) kind_eff = KIND_D;
    if (ovr && (kind == KIND_D || kind == KIND_RSV))
      kind_eff = ovr_jk ? KIND_JK : KIND_T;
  end

  always_comb begin
    q_nxt = q;
    if (clr)       q_nxt = 1'b0;
    else if (set)  q_nxt = 1'b1;
    else if (strobe) begin
      unique case (kind_eff)
        KIND_T:  q_nxt = q ^ din;
        KIND_JK: begin
          unique case ({din, kin})
            2'b11:   q_nxt = ~q;
            2'b10:   q_nxt = 1'b1;
            2'b01:   q_nxt = 1'b0;
            default: q_nxt = q;
          endcase
        end
        default: q_nxt = din;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= q_nxt;
  end

  logic rst_seen;
  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen && RESET_VAL == 1'b0)
      assert_reset_clear_R1: assert (q == 1'b0);
  end

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
  assert_preset_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr && set) |=> q);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set && !strobe) |=> $stable(q));
  assert_data_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set && strobe && kind == KIND_D && !ovr) |=> (q == $past(din)));
  assert_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set && strobe && kind == KIND_T && din) |=> (q != $past(q)));
  assert_jk_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set && strobe && kind == KIND_JK && din && !kin) |=> q);
  assert_ovr_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !set && strobe && kind == KIND_D && ovr && !ovr_jk && din)
      |=> (q != $past(q)));
endmodule

// File: rtl/mc_out_route.sv
module mc_out_route
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             q_nxt,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  input  logic             d,
  input  logic [SEL_W-1:0] pin_sel,
  input  logic [SEL_W-1:0] fb_sel,
  input  logic             d_is_oe,
  output logic             pin_o,
  output logic             fb_o,
  output logic             oe_o
);
  logic pin_mux;
  logic fb_mux;

  always_comb begin
    unique case (pin_sel)
      SEL_Q:   pin_mux = q_nxt;
      SEL_A:   pin_mux = a;
      SEL_B:   pin_mux = b;
      default: pin_mux = c;
    endcase
    unique case (fb_sel)
      SEL_Q:   fb_mux = q_nxt;
      SEL_A:   fb_mux = a;
      SEL_B:   fb_mux = b;
      default: fb_mux = d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
      fb_o  <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      pin_o <= pin_mux;
      fb_o  <= fb_mux;
      oe_o  <= d_is_oe ? d : 1'b1;
    end
  end

  assert_oe_default_R12: assert property (@(posedge clk) disable iff (rst)
    !d_is_oe |=> oe_o);
  assert_pin_route_a_R10: assert property (@(posedge clk) disable iff (rst)
    (pin_sel == SEL_A) |=> (pin_o == $past(a)));
  assert_fb_route_d_R11: assert property (@(posedge clk) disable iff (rst)
    (fb_sel == SEL_CD) |=> (fb_o == $past(d)));
endmodule

// File: rtl/logic_macrocell.sv
module logic_macrocell
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sum_a,
  input  logic             sum_b,
  input  logic             sum_c,
  input  logic             sum_d,
  input  logic             sys_clk,
  input  logic             glob_pre,
  input  logic             glob_rst,
  input  logic             type_ovr,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_ovr_jk,
  input  logic [ROLE_W-1:0] cfg_b_role,
  input  logic [ROLE_W-1:0] cfg_c_role,
  input  logic [ROLE_W-1:0] cfg_d_role,
  input  logic             cfg_clk_inv,
  input  logic [SEL_W-1:0] cfg_pin_sel,
  input  logic [SEL_W-1:0] cfg_fb_sel,
  output logic             pin_o,
  output logic             fb_o,
  output logic             oe_o
);
  logic c_clocks, d_clocks, d_enables;
  logic clr_any, set_any, k_in;
  logic strobe, q, q_nxt;

  assign c_clocks  = (cfg_c_role == C_ROLE_CLK);
  assign d_clocks  = (cfg_d_role == D_ROLE_CLK);
  assign d_enables = (cfg_d_role == D_ROLE_OE);
  assign clr_any   = glob_rst | ((cfg_c_role == C_ROLE_CLR) & sum_c);
  assign set_any   = glob_pre | ((cfg_b_role == B_ROLE_PRE) & sum_b);
  assign k_in      = (cfg_b_role == B_ROLE_K) & sum_b;

  mc_clock_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .use_c   (c_clocks),
    .use_d   (d_clocks),
    .lvl_c   (sum_c),
    .lvl_d   (sum_d),
    .lvl_sys (sys_clk),
    .invert  (cfg_clk_inv),
    .strobe  (strobe)
  );

  mc_reg_core #(.RESET_VAL(1'b0)) u_core (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .kind   (kind_e'(cfg_kind)),
    .ovr    (type_ovr),
    .ovr_jk (cfg_ovr_jk),
    .din    (sum_a),
    .kin    (k_in),
    .clr    (clr_any),
    .set    (set_any),
    .q      (q),
    .q_nxt  (q_nxt)
  );

  mc_out_route u_route (
    .clk     (clk),
    .rst     (rst),
    .q_nxt   (q_nxt),
    .a       (sum_a),
    .b       (sum_b),
    .c       (sum_c),
    .d       (sum_d),
    .pin_sel (cfg_pin_sel),
    .fb_sel  (cfg_fb_sel),
    .d_is_oe (d_enables),
    .pin_o   (pin_o),
    .fb_o    (fb_o),
    .oe_o    (oe_o)
  );

  assert_strobe_needs_source_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_any && !set_any && !strobe) |=> (q == $past(q)));
endmodule

// File: tb/logic_macrocell_tb.sv
module logic_macrocell_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0, sys_clk = 0;
  logic glob_pre = 0, glob_rst = 0, type_ovr = 0;
  logic [1:0] cfg_kind = 0, cfg_b_role = 0, cfg_c_role = 2, cfg_d_role = 2;
  logic [1:0] cfg_pin_sel = 0, cfg_fb_sel = 0;
  logic cfg_ovr_jk = 0, cfg_clk_inv = 0;
  logic pin_o, fb_o, oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic m_q, m_prev, e_pin, e_fb, e_oe;
  string tag_q;

  always #10 clk = ~clk;

  logic_macrocell dut_i (
    .clk(clk), .rst(rst), .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c),
    .sum_d(sum_d), .sys_clk(sys_clk), .glob_pre(glob_pre),
    .glob_rst(glob_rst), .type_ovr(type_ovr), .cfg_kind(cfg_kind),
    .cfg_ovr_jk(cfg_ovr_jk), .cfg_b_role(cfg_b_role),
    .cfg_c_role(cfg_c_role), .cfg_d_role(cfg_d_role),
    .cfg_clk_inv(cfg_clk_inv), .cfg_pin_sel(cfg_pin_sel),
    .cfg_fb_sel(cfg_fb_sel), .pin_o(pin_o), .fb_o(fb_o), .oe_o(oe_o)
  );

  function automatic logic pick(logic [1:0] s, logic q, logic a, logic b, logic x);
    case (s)
      2'd0: return q;
      2'd1: return a;
      2'd2: return b;
      default: return x;
    endcase
  endfunction

  // expected next state and outputs from the requirement text
  task automatic model_step();
    logic lvl, strobe, clr, set, k;
    int kind;
    if (rst) begin
      m_q = 0; m_prev = 1; e_pin = 0; e_fb = 0; e_oe = 0; tag_q = "R1";
      return;
    end
    if (cfg_c_role == 0)      lvl = sum_c;        // R6 source order
    else if (cfg_d_role == 0) lvl = sum_d;
    else                      lvl = sys_clk;
    lvl = lvl ^ cfg_clk_inv;
    strobe = lvl & ~m_prev;
    m_prev = lvl;
    clr = glob_rst | (cfg_c_role == 1 && sum_c);
    set = glob_pre | (cfg_b_role == 1 && sum_b);
    k   = (cfg_b_role == 0) ? sum_b : 1'b0;
    kind = (cfg_kind == 3) ? 0 : int'(cfg_kind);
    if (kind == 0 && type_ovr) kind = cfg_ovr_jk ? 2 : 1;
    if (clr)      begin m_q = 0; tag_q = "R8"; end
    else if (set) begin m_q = 1; tag_q = "R9"; end
    else if (strobe) begin
      case (kind)
        1: begin if (sum_a) m_q = ~m_q; tag_q = "R3/R6"; end
        2: begin
          if (sum_a && k) m_q = ~m_q;
          else if (sum_a) m_q = 1;
          else if (k) m_q = 0;
          tag_q = "R4/R6";
        end
        default: begin m_q = sum_a; tag_q = "R2/R6"; end
      endcase
      if ((cfg_kind == 0 || cfg_kind == 3) && type_ovr) tag_q = "R5";
    end else tag_q = "R7";
    e_pin = pick(cfg_pin_sel, m_q, sum_a, sum_b, sum_c);
    e_fb  = pick(cfg_fb_sel, m_q, sum_a, sum_b, sum_d);
    e_oe  = (cfg_d_role == 1) ? sum_d : 1'b1;
  endtask

  task automatic check1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    check1(cfg_pin_sel == 0 ? tag_q : "R10", "pin_o", pin_o, e_pin);
    check1(cfg_fb_sel == 0 ? tag_q : "R11", "fb_o", fb_o, e_fb);
    check1(rst ? "R1" : "R12", "oe_o", oe_o, e_oe);
  endtask

  task automatic drive_random();
    sum_a = 1'($urandom); sum_b = 1'($urandom);
    sum_c = 1'($urandom); sum_d = 1'($urandom);
    sys_clk  = 1'($urandom);
    glob_pre = ($urandom % 7) == 0;
    glob_rst = ($urandom % 9) == 0;
    type_ovr = ($urandom % 3) == 0;
  endtask

  task automatic step();
    @(negedge clk);
    check_outputs();
    drive_random();
    model_step();
  endtask

  task automatic start_segment(int kind, int br, int cr, int dr, int inv,
                               int ps, int fs, int oj);
    @(negedge clk);
    check_outputs();
    rst = 1;
    cfg_kind = 2'(kind); cfg_b_role = 2'(br); cfg_c_role = 2'(cr);
    cfg_d_role = 2'(dr); cfg_clk_inv = 1'(inv); cfg_pin_sel = 2'(ps);
    cfg_fb_sel = 2'(fs); cfg_ovr_jk = 1'(oj);
    drive_random();
    model_step();
    @(negedge clk);
    check_outputs();   // R1: outputs cleared by reset
    rst = 0;
    drive_random();
    model_step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_step();
    // directed corners: falling system clock toggle, JK on C clock,
    // override with D clock and local clear, local preset
    start_segment(1, 2, 2, 1, 1, 0, 3, 0);
    repeat (150) step();
    start_segment(2, 0, 0, 2, 0, 0, 2, 0);
    repeat (150) step();
    start_segment(0, 2, 1, 0, 0, 1, 0, 0);
    repeat (150) step();
    start_segment(3, 1, 2, 2, 1, 0, 0, 1);
    repeat (150) step();
    for (int s = 0; s < 40; s++) begin
      start_segment(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                    int'($urandom % 4), int'($urandom % 2), int'($urandom % 4),
                    int'($urandom % 4), int'($urandom % 2));
      repeat (200) step();
    end
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule